// File: doc/BRIEF.md
# Byte-Stuffed Frame Decoder

This block sits behind a serial byte receiver and recovers framed messages from the raw byte stream. It ignores traffic until it sees a start byte. It then collects decoded bytes into a one-frame buffer, turning the two-byte escape pairs back into their original values, until an end byte arrives. The last decoded byte of a frame is a checksum. The frame is accepted only when that byte equals the modulo-256 sum of the bytes before it.

An accepted frame is replayed on a valid/ready output stream: payload bytes only, in arrival order, with a last flag on the final byte, and with the payload length held on a side output. Faulty frames are dropped and reported by one-cycle status pulses. The input is also valid/ready. The decoder lowers `in_ready` for the whole replay, so an upstream source stalls instead of losing bytes. The output holds its byte and flags stable while `out_ready` is low.

Top module: `fsd_frame_decoder`

## Requirements
- R1: After reset, `in_ready` is 1, `out_valid` is 0 and all four status pulses are 0.
- R2: While hunting, every accepted byte other than 0x55 is discarded without any pulse or output, including 0xAA and 0xFF.
- R3: Inside a frame, 0xFF followed by 0x05 decodes to 0x55, by 0x0A to 0xAA and by 0x00 to 0xFF. Any other byte except 0xFF, 0x55 and 0xAA is stored unchanged.
- R4: After 0xFF, any code other than 0x05, 0x0A, 0x00 or 0x55 raises `esc_err` for one cycle. The frame is dropped and the decoder hunts for 0x55 again.
- R5: On 0xAA with at least one decoded byte, the last decoded byte is the checksum. If it equals the mod-256 sum of the earlier decoded bytes, `frame_ok` pulses and `frame_len` becomes the payload count (decoded bytes minus one). Otherwise `chk_err` pulses and the frame is dropped.
- R6: A frame with no decoded byte (0x55 directly followed by 0xAA) raises `chk_err`.
- R7: A 0x55 accepted anywhere inside a frame, including directly after 0xFF, discards the partial frame and starts a new one with an empty buffer and a zero count.
- R8: A decoded byte that arrives when MAX_LEN decoded bytes (checksum included) are already held raises `ovf_err`, drops the frame and returns to hunting. A frame of exactly MAX_LEN decoded bytes is accepted.
- R9: After `frame_ok`, the payload bytes appear on `out_data` in arrival order with `out_valid` high, one per `out_valid && out_ready` cycle. `out_last` is 1 only on the final byte. Data and last stay stable while `out_ready` is low.
- R10: `in_ready` is 0 from the `frame_ok` cycle until the final payload handshake, and input offered meanwhile has no effect. A frame with zero payload bytes gives no output and leaves `in_ready` at 1.
- R11: Each status pulse lasts one cycle, appears in the cycle after the byte that caused it was accepted, and at most one pulse is high at a time.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Received byte offered |
| in_data | input | 8 | Received byte |
| in_ready | output | 1 | Decoder accepts a byte this cycle |
| out_valid | output | 1 | Payload byte presented |
| out_ready | input | 1 | Consumer takes the payload byte |
| out_data | output | 8 | Payload byte |
| out_last | output | 1 | Final payload byte of the frame |
| frame_len | output | CNT_W | Payload byte count of the last good frame |
| frame_ok | output | 1 | Pulse: frame accepted |
| chk_err | output | 1 | Pulse: checksum mismatch or empty frame |
| esc_err | output | 1 | Pulse: illegal escape code |
| ovf_err | output | 1 | Pulse: frame longer than MAX_LEN |

## Verification
The bench builds the decoder with MAX_LEN set to 4. With that setting, the overflow boundary and the exact-fit frame can both be reached within a handful of bytes. It sweeps all 256 byte values as a one-byte payload and all 256 codes that can follow the escape byte. Every escape decode, every illegal code and the restart-after-escape case are therefore hit, with expected results computed arithmetically. A two-byte sweep with an irregular `out_ready` pattern exercises ordering, the last flag and stalling during replay.

// File: rtl/fsd_pkg.sv
package fsd_pkg;

  localparam logic [7:0] SYM_START = 8'h55;
  localparam logic [7:0] SYM_END   = 8'hAA;
  localparam logic [7:0] SYM_ESC   = 8'hFF;
  localparam logic [7:0] CODE_55   = 8'h05;
  localparam logic [7:0] CODE_AA   = 8'h0A;
  localparam logic [7:0] CODE_FF   = 8'h00;

  typedef enum logic [1:0] {
    PH_HUNT,
    PH_BODY,
    PH_ESC
  } rx_phase_e;

  typedef struct packed {
    logic       start;
    logic       data;
    logic       stop;
    logic       bad_esc;
    logic [7:0] value;
  } rx_event_t;

endpackage

// File: rtl/fsd_unstuff.sv
module fsd_unstuff
  import fsd_pkg::*;
(
  input  logic      clk,
  input  logic      rst_n,
  input  logic      fire_i,
  input  logic [7:0] byte_i,
  input  logic      abort_i,
  output rx_event_t ev_o
);

  rx_phase_e phase_q, phase_d;

  always_comb begin
    ev_o    = '0;
    phase_d = phase_q;
    if (fire_i) begin
      unique case (phase_q)
        PH_HUNT: begin
          if (byte_i == SYM_START) begin
            ev_o.start = 1'b1;
            phase_d    = PH_BODY;
          end
        end
        PH_BODY: begin
          if (byte_i == SYM_START) begin
            ev_o.start = 1'b1;
          end else if (byte_i == SYM_END) begin
            ev_o.stop = 1'b1;
            phase_d   = PH_HUNT;
          end else if (byte_i == SYM_ESC) begin
            phase_d = PH_ESC;
          end else begin
            ev_o.data  = 1'b1;
            ev_o.value = byte_i;
          end
        end
        PH_ESC: begin
          phase_d = PH_BODY;
          if (byte_i == SYM_START) begin
            ev_o.start = 1'b1;
          end else if (byte_i == CODE_55) begin
            ev_o.data  = 1'b1;
            ev_o.value = SYM_START;
          end else if (byte_i == CODE_AA) begin
            ev_o.data  = 1'b1;
            ev_o.value = SYM_END;
          end else if (byte_i == CODE_FF) begin
            ev_o.data  = 1'b1;
            ev_o.value = SYM_ESC;
          end else begin
            ev_o.bad_esc = 1'b1;
            phase_d      = PH_HUNT;
          end
        end
        default: phase_d = PH_HUNT;
      endcase
      if (abort_i) phase_d = PH_HUNT;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) phase_q <= PH_HUNT;
    else        phase_q <= phase_d;
  end

endmodule

// File: rtl/fsd_accum.sv
module fsd_accum #(
  parameter  int MAX_LEN = 16,
  localparam int CNT_W   = $clog2(MAX_LEN + 1),
  localparam int IDX_W   = $clog2(MAX_LEN)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start_i,
  input  logic             data_i,
  input  logic             stop_i,
  input  logic [7:0]       value_i,
  input  logic [IDX_W-1:0] rd_idx_i,
  output logic             overflow_o,
  output logic             good_o,
  output logic             bad_sum_o,
  output logic [CNT_W-1:0] len_o,
  output logic [7:0]       rd_byte_o
);

  logic [CNT_W-1:0] count_q;
  logic [7:0]       sum_q;
  logic [7:0]       tail_q;
  logic [7:0]       mem_q [MAX_LEN];
  logic             full, empty, match, store;

  assign full       = (count_q == CNT_W'(MAX_LEN));
  assign empty      = (count_q == '0);
  assign match      = (tail_q == sum_q);
  assign store      = data_i && !full;
  assign overflow_o = data_i && full;
  assign good_o     = stop_i && !empty && match;
  assign bad_sum_o  = stop_i && (empty || !match);
  assign len_o      = count_q - CNT_W'(1);
  assign rd_byte_o  = mem_q[rd_idx_i];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      count_q <= '0;
      sum_q   <= '0;
      tail_q  <= '0;
    end else if (start_i) begin
      count_q <= '0;
      sum_q   <= '0;
      tail_q  <= '0;
    end else if (store) begin
      count_q <= count_q + CNT_W'(1);
      tail_q  <= value_i;
      if (!empty) sum_q <= sum_q + tail_q;
    end
  end

  always_ff @(posedge clk) begin
    if (store) mem_q[count_q[IDX_W-1:0]] <= value_i;
  end

endmodule

// File: rtl/fsd_player.sv
module fsd_player #(
  parameter  int MAX_LEN = 16,
  localparam int CNT_W   = $clog2(MAX_LEN + 1),
  localparam int IDX_W   = $clog2(MAX_LEN)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start_i,
  input  logic [CNT_W-1:0] len_i,
  input  logic [7:0]       rd_byte_i,
  input  logic             out_ready,
  output logic             busy_o,
  output logic [IDX_W-1:0] rd_idx_o,
  output logic             out_valid,
  output logic [7:0]       out_data,
  output logic             out_last
);

  logic             busy_q;
  logic [CNT_W-1:0] idx_q, len_q;
  logic             fin;

  assign fin       = (idx_q == len_q - CNT_W'(1));
  assign busy_o    = busy_q;
  assign rd_idx_o  = idx_q[IDX_W-1:0];
  assign out_valid = busy_q;
  assign out_data  = rd_byte_i;
  assign out_last  = busy_q && fin;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      busy_q <= 1'b0;
      idx_q  <= '0;
      len_q  <= '0;
    end else if (start_i) begin
      busy_q <= (len_i != '0);
      idx_q  <= '0;
      len_q  <= len_i;
    end else if (busy_q && out_ready) begin
      if (fin) busy_q <= 1'b0;
      else     idx_q  <= idx_q + CNT_W'(1);
    end
  end

endmodule

// File: rtl/fsd_frame_decoder.sv
module fsd_frame_decoder
  import fsd_pkg::*;
#(
  parameter  int MAX_LEN = 16,
  localparam int CNT_W   = $clog2(MAX_LEN + 1),
  localparam int IDX_W   = $clog2(MAX_LEN)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             in_valid,
  input  logic [7:0]       in_data,
  output logic             in_ready,
  output logic             out_valid,
  input  logic             out_ready,
  output logic [7:0]       out_data,
  output logic             out_last,
  output logic [CNT_W-1:0] frame_len,
  output logic             frame_ok,
  output logic             chk_err,
  output logic             esc_err,
  output logic             ovf_err
);

  rx_event_t        ev;
  logic             fire, ovf, good, bad_sum, busy;
  logic [CNT_W-1:0] len;
  logic [IDX_W-1:0] rd_idx;
  logic [7:0]       rd_byte;

  assign in_ready = !busy;
  assign fire     = in_valid && in_ready;

  fsd_unstuff u_unstuff (
    .clk     (clk),
    .rst_n   (rst_n),
    .fire_i  (fire),
    .byte_i  (in_data),
    .abort_i (ovf),
    .ev_o    (ev)
  );

  fsd_accum #(.MAX_LEN(MAX_LEN)) u_accum (
    .clk        (clk),
    .rst_n      (rst_n),
    .start_i    (ev.start),
    .data_i     (ev.data),
    .stop_i     (ev.stop),
    .value_i    (ev.value),
    .rd_idx_i   (rd_idx),
    .overflow_o (ovf),
    .good_o     (good),
    .bad_sum_o  (bad_sum),
    .len_o      (len),
    .rd_byte_o  (rd_byte)
  );

  fsd_player #(.MAX_LEN(MAX_LEN)) u_player (
    .clk       (clk),
    .rst_n     (rst_n),
    .start_i   (good),
    .len_i     (len),
    .rd_byte_i (rd_byte),
    .out_ready (out_ready),
    .busy_o    (busy),
    .rd_idx_o  (rd_idx),
    .out_valid (out_valid),
    .out_data  (out_data),
    .out_last  (out_last)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      frame_ok  <= 1'b0;
      chk_err   <= 1'b0;
      esc_err   <= 1'b0;
      ovf_err   <= 1'b0;
      frame_len <= '0;
    end else begin
      frame_ok <= good;
      chk_err  <= bad_sum;
      esc_err  <= ev.bad_esc;
      ovf_err  <= ovf;
      if (good) frame_len <= len;
    end
  end

endmodule

// File: rtl/fsd_checker.sv
module fsd_checker (
  input logic       clk,
  input logic       rst_n,
  input logic       in_valid,
  input logic       in_ready,
  input logic       out_valid,
  input logic       out_ready,
  input logic [7:0] out_data,
  input logic       out_last,
  input logic       frame_ok,
  input logic       chk_err,
  input logic       esc_err,
  input logic       ovf_err
);

  logic any_status;
  assign any_status = frame_ok | chk_err | esc_err | ovf_err;

  assert_one_status_R11: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({frame_ok, chk_err, esc_err, ovf_err}));

  assert_status_follows_input_R11: assert property (@(posedge clk) disable iff (!rst_n)
    any_status |-> $past(in_valid && in_ready));

  assert_input_blocked_R10: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> !in_ready);

  assert_hold_stalled_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_ready) |=> (out_valid && $stable(out_data) && $stable(out_last)));

  assert_errors_no_output_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (chk_err || esc_err || ovf_err) |-> !out_valid);

endmodule

bind fsd_frame_decoder fsd_checker u_fsd_checker (
  .clk       (clk),
  .rst_n     (rst_n),
  .in_valid  (in_valid),
  .in_ready  (in_ready),
  .out_valid (out_valid),
  .out_ready (out_ready),
  .out_data  (out_data),
  .out_last  (out_last),
  .frame_ok  (frame_ok),
  .chk_err   (chk_err),
  .esc_err   (esc_err),
  .ovf_err   (ovf_err)
);

// File: tb/fsd_frame_decoder_tb_top.sv
`timescale 1ns/1ps
module fsd_frame_decoder_tb_top;

  localparam int MAX_LEN = 4;
  localparam int CNT_W   = $clog2(MAX_LEN + 1);

  logic             clk = 1'b0;
  logic             rst_n = 1'b0;
  logic             in_valid = 1'b0;
  logic [7:0]       in_data = 8'h00;
  logic             in_ready;
  logic             out_valid;
  logic             out_ready = 1'b0;
  logic [7:0]       out_data;
  logic             out_last;
  logic [CNT_W-1:0] frame_len;
  logic             frame_ok, chk_err, esc_err, ovf_err;

  int checks = 0;
  int errors = 0;
  bit f_ok, f_chk, f_esc, f_ovf;
  int f_len;
  logic [7:0] pl [8];

  always #2.5 clk = ~clk;

  fsd_frame_decoder #(.MAX_LEN(MAX_LEN)) dut_i (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_data(in_data),
    .in_ready(in_ready), .out_valid(out_valid), .out_ready(out_ready),
    .out_data(out_data), .out_last(out_last), .frame_len(frame_len),
    .frame_ok(frame_ok), .chk_err(chk_err), .esc_err(esc_err), .ovf_err(ovf_err)
  );

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic clr();
    f_ok = 0; f_chk = 0; f_esc = 0; f_ovf = 0; f_len = -1;
  endtask

  task automatic send(input logic [7:0] b);
    @(negedge clk);
    in_valid = 1'b1;
    in_data  = b;
    @(posedge clk);
    #1;
    in_valid = 1'b0;
    if (frame_ok) begin f_ok = 1; f_len = int'(frame_len); end
    if (chk_err) f_chk = 1;
    if (esc_err) f_esc = 1;
    if (ovf_err) f_ovf = 1;
  endtask

  task automatic send_st(input logic [7:0] b);
    if (b == 8'h55)      begin send(8'hFF); send(8'h05); end
    else if (b == 8'hAA) begin send(8'hFF); send(8'h0A); end
    else if (b == 8'hFF) begin send(8'hFF); send(8'h00); end
    else send(b);
  endtask

  task automatic send_frame(input int n);
    logic [7:0] s;
    s = 8'h00;
    send(8'h55);
    for (int i = 0; i < n; i++) begin
      send_st(pl[i]);
      s = s + pl[i];
    end
    send_st(s);
    send(8'hAA);
  endtask

  task automatic drain(input int n);
    int  got = 0;
    int  cyc = 0;
    bit  blocked = 1;
    while (got < n && cyc < 64) begin
      @(negedge clk);
      out_ready = (cyc % 3 != 1);
      cyc++;
      if (out_valid && in_ready) blocked = 0;
      if (out_valid && out_ready) begin
        chk(out_data == pl[got], "R9 payload byte", int'(out_data), int'(pl[got]));
        chk(out_last == (got == n - 1), "R9 last flag", int'(out_last), int'(got == n - 1));
        got++;
      end
      @(posedge clk);
    end
    #1;
    out_ready = 1'b0;
    chk(got == n, "R9 byte count", got, n);
    chk(blocked, "R10 in_ready low during replay", 0, 1);
    chk(!out_valid && in_ready, "R10 released after last", int'(out_valid), 0);
  endtask

  task automatic run_good(input int n, input string tag);
    clr();
    send_frame(n);
    chk(f_ok && !f_chk && !f_esc && !f_ovf, {tag, " R5 frame_ok"}, int'(f_ok), 1);
    chk(f_len == n, {tag, " R5 frame_len"}, f_len, n);
    if (n > 0) drain(n);
    else chk(!out_valid && in_ready, {tag, " R10 empty payload"}, int'(out_valid), 0);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired actual=0 expected=1");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    logic [7:0] d;
    repeat (3) @(posedge clk);
    #1;
    chk(in_ready && !out_valid, "R1 reset ready/valid", int'({in_ready, out_valid}), 2);
    chk(!(frame_ok | chk_err | esc_err | ovf_err), "R1 reset pulses", 1, 0);
    @(negedge clk);
    rst_n = 1'b1;
    @(posedge clk);
    #1;
    chk(in_ready && !out_valid, "R1 after reset", int'({in_ready, out_valid}), 2);

    // R2: junk while hunting
    clr();
    send(8'h12); send(8'hAA); send(8'hFF); send(8'h33); send(8'h00);
    chk(!(f_ok | f_chk | f_esc | f_ovf) && !out_valid, "R2 hunt discards", 1, 0);
    pl[0] = 8'h21; pl[1] = 8'h43;
    run_good(2, "R2 after junk");

    // R3 R5 R9: every byte value as a one-byte payload
    for (int b = 0; b < 256; b++) begin
      pl[0] = 8'(b);
      run_good(1, "R3 sweep");
    end

    // R9: two-byte payloads, order and last flag
    for (int b = 0; b < 256; b += 5) begin
      pl[0] = 8'(b);
      pl[1] = 8'(b * 7 + 3);
      run_good(2, "R9 pair");
    end

    // R4 R7 R6: every code after the escape byte
    for (int c = 0; c < 256; c++) begin
      clr();
      send(8'h55); send(8'hFF); send(8'(c));
      if (c == 8'h55) begin
        chk(!(f_ok | f_chk | f_esc | f_ovf), "R7 restart after escape", 1, 0);
        clr();
        send(8'hAA);
        chk(f_chk && !f_ok, "R6 empty frame after restart", int'(f_chk), 1);
      end else if (c == 8'h05 || c == 8'h0A || c == 8'h00) begin
        d = (c == 8'h05) ? 8'h55 : (c == 8'h0A) ? 8'hAA : 8'hFF;
        pl[0] = d;
        send_st(d);
        send(8'hAA);
        chk(f_ok && f_len == 1, "R3 escape decode frame", f_len, 1);
        drain(1);
      end else begin
        chk(f_esc && !f_ok && !f_chk, "R4 bad escape pulse", int'(f_esc), 1);
        clr();
        send(8'h01); send(8'hAA);
        chk(!(f_ok | f_chk | f_esc | f_ovf), "R4 hunting after bad escape", 1, 0);
      end
    end

    // R5: checksum mismatch
    clr();
    send(8'h55); send(8'h01); send(8'h02); send(8'h04); send(8'hAA);
    chk(f_chk && !f_ok && !out_valid, "R5 checksum mismatch", int'(f_chk), 1);

    // R6: empty frame
    clr();
    send(8'h55); send(8'hAA);
    chk(f_chk && !f_ok, "R6 empty frame", int'(f_chk), 1);

    // R7: restart mid-frame
    clr();
    send(8'h55); send(8'h11); send(8'h22); send(8'h55); send(8'h33); send(8'h33); send(8'hAA);
    chk(f_ok && f_len == 1, "R7 restart mid-frame", f_len, 1);
    pl[0] = 8'h33;
    drain(1);

    // R8: overflow and exact fit
    clr();
    send(8'h55);
    for (int i = 1; i <= MAX_LEN; i++) send(8'(i));
    chk(!f_ovf, "R8 no overflow at limit", int'(f_ovf), 0);
    send(8'h09);
    chk(f_ovf && !f_ok, "R8 overflow pulse", int'(f_ovf), 1);
    clr();
    send(8'h0A); send(8'hAA);
    chk(!(f_ok | f_chk | f_esc | f_ovf), "R8 hunting after overflow", 1, 0);
    pl[0] = 8'h10; pl[1] = 8'hFF; pl[2] = 8'h55;
    run_good(MAX_LEN - 1, "R8 exact fit");

    // R10: checksum-only frame, and input ignored during replay
    pl[0] = 8'h00;
    run_good(0, "R10 zero payload");
    clr();
    pl[0] = 8'h5A; pl[1] = 8'hC3;
    send_frame(2);
    chk(f_ok, "R10 frame before replay", int'(f_ok), 1);
    @(posedge clk);
    #1;
    chk(!frame_ok, "R11 pulse lasts one cycle", int'(frame_ok), 0);
    in_valid = 1'b1;
    in_data  = 8'h55;
    drain(2);
    in_valid = 1'b0;
    clr();
    send(8'hAA);
    chk(!(f_ok | f_chk | f_esc | f_ovf), "R10 input ignored during replay", 1, 0);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule